// File: doc/BRIEF.md
# Move-Machine Control Core

This block is the sequencer of a computer that has only one instruction: copy a word from a source address to a destination address. Arithmetic, I/O, storage and jumps all live in memory-mapped modules outside the core. The core is the only bus master. It holds the program counter and drives the address bus, the write strobe and the write-data bus. Read data returns on the same cycle, through a combinational path.

An instruction is two consecutive words at the program counter: a source operand word, then a destination operand word. When the top bit of an operand word is set, the operand is indirect. The core reads the word at the stripped address and uses that word as the real address. Every bus address the core resolves has its top bit cleared, so 2^(WORD_W-1) locations can be reached. A direct instruction takes 4 cycles. Each indirect operand adds one cycle.

An external jump module reads `pc_o`. It can replace the increment that the write step would make by asserting `pc_load_i`.

Top module: `mm_core`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `pc_o` is 0, `we_o` is 0 and `addr_o` equals `pc_o` (the source-pointer fetch step).
- R2: A source operand word whose bit WORD_W-1 is 0 is used directly. The cycle after the pointer fetch is the value read at that address.
- R3: A source operand word whose bit WORD_W-1 is 1 adds one dereference cycle. That cycle reads at the word's low WORD_W-1 bits, and the word read there becomes the source address.
- R4: The destination operand follows the same bit WORD_W-1 rule as the source, with the same one-cycle dereference.
- R5: Indirection is single-level. The top bit of a dereferenced word is ignored, and only its low WORD_W-1 bits form the address.
- R6: `pc_o` increments by 1 in the value-read step and again in the write step. It is unchanged in every other step, so a direct instruction advances it by 2 in 4 cycles.
- R7: `we_o` is high for exactly one cycle per instruction. In that cycle `addr_o` is the resolved destination and `wdata_o` is the value read from the resolved source.
- R8: If `pc_load_i` is high in the write step, `pc_o` takes `pc_load_val_i` on the next cycle instead of incrementing.
- R9: `pc_load_i` has no effect in any step other than the write step.
- R10: In the dereference, value-read and write steps, bit WORD_W-1 of `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_o | output | WORD_W | Bus address |
| we_o | output | 1 | Write strobe |
| wdata_o | output | WORD_W | Write data |
| rdata_i | input | WORD_W | Read data, valid in the same cycle as `addr_o` |
| pc_o | output | WORD_W | Program counter |
| pc_load_i | input | 1 | Jump load enable, sampled only in the write step |
| pc_load_val_i | input | WORD_W | Jump target |

## Verification
On every cycle, assertions check the following:
- the step order, including the skip or entry of each dereference step based on the flag bit;
- the points at which the program counter holds, increments or loads;
- the one-cycle write strobe;
- the cleared top bit on every resolved address.

Only the bench scenarios can show that the right data moves. This covers the value landing at the resolved destination through direct, source-indirect, destination-indirect and double-flagged pointers, as well as per-instruction cycle counts and whether a jump load issued outside the write step is ignored.

// File: rtl/mm_core_pkg.sv
package mm_core_pkg;
  typedef enum logic [2:0] {
    ST_SRC_PTR   = 3'd0,
    ST_SRC_DEREF = 3'd1,
    ST_SRC_READ  = 3'd2,
    ST_DST_PTR   = 3'd3,
    ST_DST_DEREF = 3'd4,
    ST_WRITE     = 3'd5
  } step_e;
endpackage

// File: rtl/mm_seq.sv
module mm_seq
  import mm_core_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ind_flag_i,
  output step_e step_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_SRC_PTR:   step_d = ind_flag_i ? ST_SRC_DEREF : ST_SRC_READ;
      ST_SRC_DEREF: step_d = ST_SRC_READ;
      ST_SRC_READ:  step_d = ST_DST_PTR;
      ST_DST_PTR:   step_d = ind_flag_i ? ST_DST_DEREF : ST_WRITE;
      ST_DST_DEREF: step_d = ST_WRITE;
      ST_WRITE:     step_d = ST_SRC_PTR;
      default:      step_d = ST_SRC_PTR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_SRC_PTR;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  AST_SRC_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_SRC_PTR && !ind_flag_i) |=> step_q == ST_SRC_READ); // R2
  AST_SRC_INDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_SRC_PTR && ind_flag_i) |=> step_q == ST_SRC_DEREF); // R3
  AST_DST_INDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_DST_PTR && ind_flag_i) |=> step_q == ST_DST_DEREF); // R4
  AST_DEREF_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_SRC_DEREF || step_q == ST_DST_DEREF) |=>
    (step_q == ST_SRC_READ || step_q == ST_WRITE)); // R5
endmodule

// File: rtl/mm_pc.sv
module mm_pc
  import mm_core_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  output logic [WORD_W-1:0] pc_o
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
  logic [WORD_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (step_i == ST_SRC_READ)  pc_d = pc_q + ONE;
    else if (step_i == ST_WRITE) pc_d = load_i ? load_val_i : pc_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_READ_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_SRC_READ) |=> pc_q == $past(pc_q) + ONE); // R6
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != ST_SRC_READ && step_i != ST_WRITE) |=> pc_q == $past(pc_q)); // R9
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_WRITE && load_i) |=> pc_q == $past(load_val_i)); // R8
  AST_PC_WR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_WRITE && !load_i) |=> pc_q == $past(pc_q) + ONE); // R6
endmodule

// File: rtl/mm_opnd.sv
module mm_opnd
  import mm_core_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] addr_o,
  output logic              we_o,
  output logic [WORD_W-1:0] wdata_o
);
  localparam int unsigned FLAG_BIT = WORD_W - 1;
  localparam logic [WORD_W-1:0] ADDR_MASK = {1'b0, {(WORD_W-1){1'b1}}};

  logic [WORD_W-1:0] src_q, dst_q, val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      val_q <= '0;
    end else begin
      unique case (step_i)
        ST_SRC_PTR, ST_SRC_DEREF: src_q <= rdata_i;
        ST_SRC_READ:              val_q <= rdata_i;
        ST_DST_PTR, ST_DST_DEREF: dst_q <= rdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (step_i)
      ST_SRC_DEREF, ST_SRC_READ: addr_o = src_q & ADDR_MASK;
      ST_DST_DEREF, ST_WRITE:    addr_o = dst_q & ADDR_MASK;
      default:                   addr_o = pc_i;
    endcase
  end

  assign we_o    = (step_i == ST_WRITE);
  assign wdata_o = val_q;

  AST_ADDR_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != ST_SRC_PTR && step_i != ST_DST_PTR) |-> !addr_o[FLAG_BIT]); // R10
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o); // R7
  AST_WDATA_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_SRC_READ) |=> wdata_o == $past(rdata_i)); // R7
endmodule

// File: rtl/mm_core.sv
module mm_core
  import mm_core_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [WORD_W-1:0] addr_o,
  output logic              we_o,
  output logic [WORD_W-1:0] wdata_o,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] pc_o,
  input  logic              pc_load_i,
  input  logic [WORD_W-1:0] pc_load_val_i
);
  localparam int unsigned FLAG_BIT = WORD_W - 1;

  step_e step;

  mm_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ind_flag_i (rdata_i[FLAG_BIT]),
    .step_o     (step)
  );

  mm_pc #(.WORD_W(WORD_W)) i_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .load_i     (pc_load_i),
    .load_val_i (pc_load_val_i),
    .pc_o       (pc_o)
  );

  mm_opnd #(.WORD_W(WORD_W)) i_opnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .pc_i    (pc_o),
    .rdata_i (rdata_i),
    .addr_o  (addr_o),
    .we_o    (we_o),
    .wdata_o (wdata_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && !we_o)); // R1
endmodule

// File: tb/test_mm_core.sv
module test_mm_core;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] addr, wdata, rdata, pc, ld_val;
  logic         we, ld;
  logic [W-1:0] mem [256];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mm_core #(.WORD_W(W)) i_mm_core (
    .clk_i(clk), .rst_ni(rst_n), .addr_o(addr), .we_o(we), .wdata_o(wdata),
    .rdata_i(rdata), .pc_o(pc), .pc_load_i(ld), .pc_load_val_i(ld_val)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs one instruction from a negedge at its first step; mode 1 holds load, mode 2 pulses it in step 1 only.
  task automatic run_instr(int exp_cycles, int mode, logic [W-1:0] tgt, string req,
                           output logic [W-1:0] waddr, output logic [W-1:0] wval);
    int n = 0;
    ld_val = tgt;
    ld = (mode != 0);
    forever begin
      n++;
      if (we) break;
      if (n > 10) break;
      @(negedge clk);
      if (mode == 2) ld = 1'b0;
    end
    waddr = addr;
    wval  = wdata;
    check({req, " cycles"}, n, exp_cycles);
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 pc", pc, 0);
    check("R1 we", we, 0);
    check("R1 addr", addr, 0);
  endtask

  task automatic t_direct;
    logic [W-1:0] a, v;
    int we_cnt;
    run_instr(4, 0, 0, "R2", a, v);
    check("R2 dest", mem[8'h20], 8'hA5);
    check("R7 addr", a, 8'h20);
    check("R7 data", v, 8'hA5);
    check("R6 pc", pc, 2);
  endtask

  task automatic t_src_ind;
    logic [W-1:0] a, v;
    run_instr(5, 0, 0, "R3", a, v);
    check("R3 dest", mem[8'h21], 8'h5C);
    check("R6 pc", pc, 4);
  endtask

  task automatic t_dst_ind;
    logic [W-1:0] a, v;
    run_instr(5, 0, 0, "R4", a, v);
    check("R4 dest", mem[8'h22], 8'h77);
    check("R10 addr", a, 8'h22);
  endtask

  task automatic t_single_level;
    logic [W-1:0] a, v;
    run_instr(5, 0, 0, "R5", a, v);
    check("R5 dest", mem[8'h23], 8'h3C);
    check("R5 pc", pc, 8);
  endtask

  task automatic t_jump;
    logic [W-1:0] a, v;
    run_instr(4, 1, 8'h40, "R8", a, v);
    check("R8 pc", pc, 8'h40);
    check("R8 dest", mem[8'h24], 8'hC3);
  endtask

  task automatic t_load_ignored;
    logic [W-1:0] a, v;
    run_instr(4, 2, 8'h70, "R9", a, v);
    check("R9 pc", pc, 8'h42);
    check("R9 dest", mem[8'h25], 8'h18);
  endtask

  task automatic t_strobe_count;
    int cnt = 0;
    for (int i = 0; i < 14; i++) begin
      if (we) cnt++;
      @(negedge clk);
    end
    // 0x42: direct then direct, each 4 cycles; 14 cycles covers 3 strobes + partial
    check("R7 strobes", cnt, 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    ld = 1'b0; ld_val = '0;
    mem[0] = 8'h10; mem[1] = 8'h20; mem[8'h10] = 8'hA5;
    mem[2] = 8'hB0; mem[3] = 8'h21; mem[8'h30] = 8'h11; mem[8'h11] = 8'h5C;
    mem[4] = 8'h12; mem[5] = 8'hB1; mem[8'h12] = 8'h77; mem[8'h31] = 8'h22;
    mem[6] = 8'hB2; mem[7] = 8'h23; mem[8'h32] = 8'h93; mem[8'h13] = 8'h3C;
    mem[8] = 8'h14; mem[9] = 8'h24; mem[8'h14] = 8'hC3;
    mem[8'h40] = 8'h15; mem[8'h41] = 8'h25; mem[8'h15] = 8'h18;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_src_ind();
    t_dst_ind();
    t_single_level();
    t_jump();
    t_load_ignored();
    t_strobe_count();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule